// File: doc/BRIEF.md
# Power-of-Two Moving Average Filter

This block smooths a stream of 14-bit two's complement sensor samples with a boxcar average. The window holds 2^M samples, and M is taken live from a 4-bit exponent input that a control register drives. Each accepted sample updates a running sum. The sample that falls out of the window is read back from a circular history memory and subtracted. The mean is the running sum shifted right arithmetically by M.

The result goes out as a 16-bit word. The top bit is a new-data flag that a read strobe clears. The next bit is a registered copy of an external error/alarm flag. The low 14 bits are the averaged sample. A one-cycle valid pulse marks each fresh result. When the effective exponent changes, the filter flushes its history and produces no result until the new window has filled again.

Top module: `movavg_filter`

## Requirements
- R1: Once the window is full, each accepted sample yields the mean of the most recent 2^M accepted samples, where M is the effective exponent.
- R2: An exponent input above 8 acts as 8. A change of the input between two values that both clamp to 8 causes no flush.
- R3: The running sum is 22 bits wide. A window of 256 samples all at +8191 yields +8191, and a window of 256 samples all at -8192 yields -8192.
- R4: A change of the effective exponent clears the history. A sample presented in the same cycle as that change is discarded. No valid pulse appears until 2^M new samples have arrived.
- R5: `outValid` is a one-cycle pulse in the cycle after an accepted sample that leaves the window full. The data field holds its value in every cycle without a pulse.
- R6: Output word layout: bit 15 is the new-data flag, bit 14 is `errFlag` delayed by one cycle, and bits 13:0 are the two's complement mean.
- R7: The new-data flag is 1 in every cycle where `outValid` is 1. A read strobe with no update in the same cycle clears the flag in the next cycle. If a read and an update fall in the same cycle, the flag stays 1.
- R8: During reset and after it, `outWord` is 0 and `outValid` is 0. The reset exponent is 4, so with the input held at 4 the first result follows the 16th sample.
- R9: The division rounds toward negative infinity. With M=1, the samples -1 and 0 give -1, and the samples -3 and -4 give -4.
- R10: With M=0 each accepted sample is passed to the output unchanged, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| smplValid | input | 1 | Sample strobe |
| smplData | input | 14 | Sample, two's complement |
| avgExp | input | 4 | Window exponent M |
| errFlag | input | 1 | Error/alarm flag carried into bit 14 |
| rdStrobe | input | 1 | Output word read, clears the new-data flag |
| outWord | output | 16 | {new-data, error, 14-bit mean} |
| outValid | output | 1 | One-cycle pulse for a fresh mean |

## Verification
A corrupted running sum or history pointer shows up as a wrong mean on the first valid pulse after the fault. If the error sits only in the subtraction of the oldest sample, it appears once the window has wrapped, which takes 2^M samples at most. A wrong fill count shows as a valid pulse one sample too early or too late after a flush, and the bench checks this on every sample. Faults in the flag logic show in the cycle right after the read or the update that should have changed bit 15.

// File: rtl/movavg_pkg.sv
package movavg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic flush;       // exponent changed: clear sum
    logic push;        // accept sample into history and sum
    logic dropOldest;  // window full: subtract expiring sample
    logic publish;     // load the output register
  } avgStrobe_t;
endpackage

// File: rtl/movavg_ctl.sv
module movavg_ctl
  import movavg_pkg::*;
#(
  parameter int MAX_EXP = 8,
  parameter int EXP_W   = 4,
  parameter int RST_EXP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             smplValid,
  input  logic [EXP_W-1:0] avgExp,
  input  logic             rdStrobe,
  output avgStrobe_t       strb,
  output logic [EXP_W-1:0] curExp,
  output logic             outValid,
  output logic             newData
);
  localparam int CNT_W = MAX_EXP + 1;

  logic [EXP_W-1:0] expClamp;
  logic [CNT_W-1:0] winLen;
  logic [CNT_W-1:0] fillCnt;
  logic             winFull;
  logic             lastFill;

  assign expClamp = (avgExp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : avgExp;
  assign winLen   = CNT_W'(1) << curExp;
  assign winFull  = (fillCnt == winLen);
  assign lastFill = ((fillCnt + CNT_W'(1)) == winLen);

  always_comb begin
    strb.flush      = (expClamp != curExp);
    strb.push       = smplValid & ~strb.flush;
    strb.dropOldest = strb.push & winFull;
    strb.publish    = strb.push & (winFull | lastFill);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curExp  <= EXP_W'(RST_EXP);
      fillCnt <= '0;
    end else if (strb.flush) begin
      curExp  <= expClamp;
      fillCnt <= '0;
    end else if (strb.push && !winFull) begin
      fillCnt <= fillCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      newData  <= 1'b0;
    end else begin
      outValid <= strb.publish;
      if (strb.publish)  newData <= 1'b1;
      else if (rdStrobe) newData <= 1'b0;
    end
  end
endmodule

// File: rtl/movavg_dp.sv
module movavg_dp
  import movavg_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int MAX_EXP = 8,
  parameter int EXP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  avgStrobe_t        strb,
  input  logic [EXP_W-1:0]  curExp,
  input  logic [DATA_W-1:0] smplData,
  input  logic              errFlag,
  output logic [DATA_W-1:0] outData,
  output logic              errQ
);
  localparam int DEPTH = 1 << MAX_EXP;
  localparam int SUM_W = DATA_W + MAX_EXP;
  localparam int CNT_W = MAX_EXP + 1;

  logic [DATA_W-1:0]         hist [DEPTH];
  logic [MAX_EXP-1:0]        wrPtr;
  logic [MAX_EXP-1:0]        rdIdx;
  logic [CNT_W-1:0]          winLen;
  logic [DATA_W-1:0]         oldest;
  logic signed [SUM_W-1:0]   runSum;
  logic signed [SUM_W-1:0]   nextSum;
  logic signed [SUM_W-1:0]   addTerm;
  logic signed [SUM_W-1:0]   subTerm;
  logic signed [SUM_W-1:0]   shifted;

  // Oldest entry sits 2^M writes behind; at 256 that wraps onto wrPtr itself
  assign winLen  = CNT_W'(1) << curExp;
  assign rdIdx   = wrPtr - winLen[MAX_EXP-1:0];
  assign oldest  = strb.dropOldest ? hist[rdIdx] : '0;
  assign addTerm = {{MAX_EXP{smplData[DATA_W-1]}}, smplData};
  assign subTerm = {{MAX_EXP{oldest[DATA_W-1]}}, oldest};
  assign nextSum = runSum + addTerm - subTerm;
  assign shifted = nextSum >>> curExp;

  always_ff @(posedge clk) begin
    if (strb.push) hist[wrPtr] <= smplData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      runSum  <= '0;
      outData <= '0;
      errQ    <= 1'b0;
    end else begin
      errQ <= errFlag;
      if (strb.flush) begin
        runSum <= '0;
      end else if (strb.push) begin
        runSum <= nextSum;
        wrPtr  <= wrPtr + MAX_EXP'(1);
      end
      if (strb.publish) outData <= shifted[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/movavg_filter.sv
module movavg_filter
  import movavg_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int MAX_EXP = 8,
  parameter int EXP_W   = 4,
  parameter int RST_EXP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smplValid,
  input  logic [DATA_W-1:0] smplData,
  input  logic [EXP_W-1:0]  avgExp,
  input  logic              errFlag,
  input  logic              rdStrobe,
  output logic [DATA_W+1:0] outWord,
  output logic              outValid
);
  avgStrobe_t        strb;
  logic [EXP_W-1:0]  curExp;
  logic              newData;
  logic              errQ;
  logic [DATA_W-1:0] outData;

  movavg_ctl #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W), .RST_EXP(RST_EXP)) u_ctl (
    .clk(clk), .rstN(rstN), .smplValid(smplValid), .avgExp(avgExp),
    .rdStrobe(rdStrobe), .strb(strb), .curExp(curExp),
    .outValid(outValid), .newData(newData)
  );

  movavg_dp #(.DATA_W(DATA_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curExp(curExp),
    .smplData(smplData), .errFlag(errFlag), .outData(outData), .errQ(errQ)
  );

  assign outWord = {newData, errQ, outData};
endmodule

// File: rtl/movavg_chk.sv
module movavg_chk #(
  parameter int DATA_W  = 14,
  parameter int MAX_EXP = 8,
  parameter int EXP_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              smplValid,
  input logic [DATA_W-1:0] smplData,
  input logic              errFlag,
  input logic              rdStrobe,
  input logic [DATA_W+1:0] outWord,
  input logic              outValid,
  input logic              flushStb,
  input logic              publishStb,
  input logic [EXP_W-1:0]  curExp
);
  p_exp_clamped_r2: assert property (@(posedge clk) disable iff (!rstN)
    curExp <= EXP_W'(MAX_EXP));

  p_flush_no_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |=> !outValid);

  p_valid_after_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(smplValid));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outWord[DATA_W-1:0]));

  p_err_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outWord[DATA_W] == $past(errFlag));

  p_nd_on_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outWord[DATA_W+1]);

  p_nd_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !publishStb) |=> !outWord[DATA_W+1]);

  p_passthru_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && curExp == '0) |-> outWord[DATA_W-1:0] == $past(smplData));
endmodule

bind movavg_filter movavg_chk #(.DATA_W(DATA_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rstN(rstN), .smplValid(smplValid), .smplData(smplData),
  .errFlag(errFlag), .rdStrobe(rdStrobe), .outWord(outWord), .outValid(outValid),
  .flushStb(strb.flush), .publishStb(strb.publish), .curExp(curExp)
);

// File: tb/movavg_filter_bench.sv
module movavg_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        smplValid = 1'b0;
  logic [13:0] smplData = '0;
  logic [3:0]  avgExp = 4'd4;
  logic        errFlag = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [15:0] outWord;
  logic        outValid;

  int testsRun = 0;
  int failed = 0;
  int effExp = 4;
  int hist[$];

  always #5 clk = ~clk;

  movavg_filter u_movavg_filter (
    .clk(clk), .rstN(rstN), .smplValid(smplValid), .smplData(smplData),
    .avgExp(avgExp), .errFlag(errFlag), .rdStrobe(rdStrobe),
    .outWord(outWord), .outValid(outValid)
  );

  function automatic int clampExp(input int e);
    return (e > 8) ? 8 : e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    testsRun++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Presents one sample; checks valid and mean against the bench model
  task automatic sendSample(input int v, input string tag);
    longint s;
    bit expV;
    int expD;
    int actD;
    smplValid = 1'b1;
    smplData  = v[13:0];
    hist.push_back(v);
    if (hist.size() > (1 << effExp)) void'(hist.pop_front());
    expV = (hist.size() == (1 << effExp));
    s = 0;
    foreach (hist[i]) s += hist[i];
    expD = int'(s >>> effExp);
    @(posedge clk);
    @(negedge clk);
    smplValid = 1'b0;
    check(outValid == expV, {tag, " valid"}, int'(outValid), int'(expV));
    if (expV) begin
      actD = int'($signed(outWord[13:0]));
      check(actD == expD, {tag, " mean"}, actD, expD);
      check(outWord[15] == 1'b1, {tag, " R7 new-data set"}, int'(outWord[15]), 1);
    end
  endtask

  task automatic setExp(input int e);
    avgExp = e[3:0];
    @(posedge clk);
    @(negedge clk);
    if (clampExp(e) != effExp) begin
      effExp = clampExp(e);
      hist.delete();
    end
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R8 reset valid", int'(outValid), 0);
    check(outWord == 16'h0, "R8 reset word", int'(outWord), 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(outWord == 16'h0, "R8 word after reset", int'(outWord), 0);
  endtask

  task automatic testDefaultWindow();
    for (int i = 0; i < 40; i++) sendSample(((i * 173) % 900) - 450, "R8 R1 default window");
  endtask

  task automatic testPassthrough();
    setExp(0);
    sendSample(8191, "R10 passthru max");
    sendSample(-8192, "R10 passthru min");
    sendSample(-1, "R10 passthru -1");
    sendSample(1234, "R10 passthru");
  endtask

  task automatic testRounding();
    setExp(1);
    sendSample(-1, "R9 fill");
    sendSample(0, "R9 floor -1,0");
    sendSample(3, "R9 pair");
    sendSample(4, "R9 floor 3,4");
    sendSample(-3, "R9 pair");
    sendSample(-4, "R9 floor -3,-4");
  endtask

  task automatic testFullScale();
    setExp(8);
    for (int i = 0; i < 256; i++) sendSample(8191, "R3 full scale pos");
    for (int i = 0; i < 256; i++) sendSample(-8192, "R3 full scale neg");
    for (int i = 0; i < 300; i++) sendSample(((i * 811) % 16000) - 8000, "R1 window 256 wrap");
  endtask

  task automatic testClamp();
    setExp(12);
    sendSample(77, "R2 no flush 8 to 12");
    setExp(2);
    setExp(15);
    for (int i = 0; i < 260; i++) sendSample((i % 50) - 25, "R2 clamp 15 to 8");
  endtask

  task automatic testFlush();
    setExp(2);
    for (int i = 0; i < 6; i++) sendSample(i * 100, "R4 fill M2");
    avgExp = 4'd3;
    smplValid = 1'b1;
    smplData = 14'd5000;
    @(posedge clk);
    @(negedge clk);
    smplValid = 1'b0;
    check(outValid == 1'b0, "R4 sample in change cycle", int'(outValid), 0);
    effExp = 3;
    hist.delete();
    for (int i = 0; i < 10; i++) sendSample(-i * 7, "R4 refill M3");
  endtask

  task automatic testFlags();
    setExp(1);
    sendSample(10, "R7 fill");
    sendSample(20, "R7 publish");
    rdStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdStrobe = 1'b0;
    check(outWord[15] == 1'b0, "R7 read clears", int'(outWord[15]), 0);
    check(int'($signed(outWord[13:0])) == 15, "R5 data kept after read",
          int'($signed(outWord[13:0])), 15);
    rdStrobe = 1'b1;
    sendSample(30, "R7 read with update");
    rdStrobe = 1'b0;
    check(outWord[15] == 1'b1, "R7 update wins", int'(outWord[15]), 1);
    errFlag = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(outWord[14] == 1'b1, "R6 error bit set", int'(outWord[14]), 1);
    errFlag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(outWord[14] == 1'b0, "R6 error bit clear", int'(outWord[14]), 0);
    check(int'($signed(outWord[13:0])) == 25, "R6 data field", int'($signed(outWord[13:0])), 25);
  endtask

  task automatic testHold();
    logic [13:0] held;
    held = outWord[13:0];
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(outValid == 1'b0, "R5 idle no pulse", int'(outValid), 0);
      check(outWord[13:0] == held, "R5 data held", int'(outWord[13:0]), int'(held));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testDefaultWindow();
    testHold();
    testPassthrough();
    testRounding();
    testFullScale();
    testClamp();
    testFlush();
    testFlags();
    $display("  [TB] %0d tests run, %0d failed", testsRun, failed);
    $finish;
  end
endmodule